// File: doc/BRIEF.md
# Received pause handling and transmit stall

This block sits behind the receive parser of an Ethernet MAC. For every parsed frame it is handed the EtherType, the control opcode and the 16-bit quanta field. From these it decides three things. It decides whether a MAC control frame goes on to the client or is discarded. It decides whether a pause frame should stall the local transmitter. It pulses a strobe for each pause frame seen, which feeds a statistics counter.

A pause frame has EtherType 0x8808 and opcode 0x0001. Its quanta value loads a countdown, and each quantum lasts 512 bit-times, measured on an external bit-time tick. A new pause frame replaces whatever remains of the countdown. The stall output only rises between transmitted frames, so a frame already being sent is never cut.

Three configuration inputs govern the block:
- `cfg_ignore` separates acting on a pause frame from delivering it.
- `cfg_forward` chooses whether pause frames are delivered or dropped.
- `cfg_cmd_en` chooses whether other control opcodes are accepted.

The block also holds the 16-bit quanta value that the transmit side will place in outgoing pause frames.

Top module: `pause_flow_ctl`

## Requirements
- R1: After reset `tx_hold`, `pause_pulse`, `fwd` and `drop` are 0, and `txq` reads 0xF000.
- R2: A frame strobed with `ctl_ethtype`=0x8808 and `ctl_opcode`=0x0001 is a pause frame. It produces a one-cycle `pause_pulse` on the cycle after the strobe, whatever the configuration.
- R3: A pause frame raises `fwd` on the cycle after the strobe when `cfg_forward`=1, and raises `drop` instead when `cfg_forward`=0. `fwd` and `drop` are never high together.
- R4: A frame with EtherType 0x8808 and any other opcode raises `fwd` when `cfg_cmd_en`=1 and `drop` when `cfg_cmd_en`=0. It never raises `pause_pulse`.
- R5: With `cfg_ignore`=0 and `tx_busy`=0, a pause frame carrying quanta Q≠0 raises `tx_hold` two cycles after the strobe. `tx_hold` then stays high until Q×512 `bit_tick` pulses have been counted after the strobe cycle.
- R6: With `cfg_ignore`=1, a pause frame leaves `tx_hold` unchanged, whatever its quanta value.
- R7: A pause frame that arrives while a stall is counting replaces the remaining time with its own quanta and does not add to it.
- R8: A pause frame with quanta 0 (and `cfg_ignore`=0) drops `tx_hold` two cycles after the strobe.
- R9: `tx_hold` can only rise on a cycle following one where `tx_busy` was 0. While `tx_busy` stays 1, a pending stall waits.
- R10: A cycle with `txq_we`=1 loads `txq_wdata` into `txq`, visible on the next cycle. Otherwise `txq` holds its value.
- R11: A strobed frame whose EtherType is not 0x8808 raises none of `fwd`, `drop` or `pause_pulse`.
- R12: The stall countdown advances only on cycles with `bit_tick`=1. Without ticks `tx_hold` stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | One-cycle strobe: parsed frame header fields are valid |
| ctl_ethtype | input | 16 | EtherType of the parsed frame |
| ctl_opcode | input | 16 | MAC control opcode |
| ctl_quanta | input | 16 | Quanta field of a pause frame |
| cfg_ignore | input | 1 | 1: received pause frames do not stall transmission |
| cfg_forward | input | 1 | 1: deliver pause frames to the client; 0: drop them |
| cfg_cmd_en | input | 1 | 1: accept non-pause control frames; 0: reject them |
| bit_tick | input | 1 | One pulse per bit-time |
| tx_busy | input | 1 | Transmitter is inside a frame |
| txq_we | input | 1 | Write strobe for the outgoing quanta value |
| txq_wdata | input | 16 | New outgoing quanta value |
| tx_hold | output | 1 | Transmitter must not start a new frame |
| pause_pulse | output | 1 | One pulse per received pause frame |
| fwd | output | 1 | Control frame is delivered to the client |
| drop | output | 1 | Control frame is discarded |
| txq | output | 16 | Outgoing pause quanta value |

## Verification
The embedded assertions check several rules on every cycle:
- `fwd` and `drop` never coincide.
- `pause_pulse` only follows a genuine pause strobe.
- `tx_hold` never rises right after a busy cycle.
- The countdown neither moves without a tick nor grows under an ignored pause.
- A zero-quanta pause clears the stall.

Only the bench scenarios can show the exact stall length in bit-ticks, and that a reload shortens rather than extends the remaining time. They also show how the decisions to deliver or to drop follow each combination of configuration bits, and that a deferred stall starts as soon as the transmitter goes idle.

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl #(
  parameter int          QW                = 16,
  parameter int          TICKS_PER_QUANTUM = 512,
  parameter logic [15:0] CTL_ETYPE         = 16'h8808,
  parameter logic [15:0] PAUSE_OP          = 16'h0001,
  parameter logic [QW-1:0] TXQ_INIT        = QW'('hF000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_valid,
  input  logic [15:0]   ctl_ethtype,
  input  logic [15:0]   ctl_opcode,
  input  logic [QW-1:0] ctl_quanta,
  input  logic          cfg_ignore,
  input  logic          cfg_forward,
  input  logic          cfg_cmd_en,
  input  logic          bit_tick,
  input  logic          tx_busy,
  input  logic          txq_we,
  input  logic [QW-1:0] txq_wdata,
  output logic          tx_hold,
  output logic          pause_pulse,
  output logic          fwd,
  output logic          drop,
  output logic [QW-1:0] txq
);

  localparam int SW = (TICKS_PER_QUANTUM > 1) ? $clog2(TICKS_PER_QUANTUM) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_QUANTUM - 1);

  logic          is_ctl, is_pause, is_cmd, load, timer_on;
  logic [QW-1:0] rem_q;
  logic [SW-1:0] sub_cnt;

  assign is_ctl   = ctl_valid && (ctl_ethtype == CTL_ETYPE);
  assign is_pause = is_ctl && (ctl_opcode == PAUSE_OP);
  assign is_cmd   = is_ctl && (ctl_opcode != PAUSE_OP);
  assign load     = is_pause && !cfg_ignore;
  assign timer_on = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      sub_cnt <= '0;
    end else if (load) begin
      rem_q   <= ctl_quanta;
      sub_cnt <= '0;
    end else if (bit_tick && timer_on) begin
      if (sub_cnt == SUB_LAST) begin
        sub_cnt <= '0;
        rem_q   <= rem_q - 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold     <= 1'b0;
      pause_pulse <= 1'b0;
      fwd         <= 1'b0;
      drop        <= 1'b0;
      txq         <= TXQ_INIT;
    end else begin
      tx_hold     <= timer_on && (tx_hold || !tx_busy);
      pause_pulse <= is_pause;
      fwd         <= (is_pause && cfg_forward) || (is_cmd && cfg_cmd_en);
      drop        <= (is_pause && !cfg_forward) || (is_cmd && !cfg_cmd_en);
      if (txq_we) txq <= txq_wdata;
    end
  end

  assert_fwd_drop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd && drop));

  assert_pulse_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_pulse |-> $past(ctl_valid && ctl_ethtype == CTL_ETYPE && ctl_opcode == PAUSE_OP));

  assert_cmd_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ethtype == CTL_ETYPE && ctl_opcode != PAUSE_OP) |=> !pause_pulse);

  assert_hold_rise_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> !$past(tx_busy));

  assert_no_tick_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !ctl_valid) |=> ($stable(rem_q) && $stable(sub_cnt)));

  assert_ignore_no_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pause && cfg_ignore) |=> (rem_q <= $past(rem_q)));

  assert_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ctl_quanta == '0) |=> ##1 !tx_hold);

  assert_other_type_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ethtype != CTL_ETYPE) |=> !(fwd || drop || pause_pulse));

endmodule

// File: tb/pause_flow_ctl_bench.sv
module pause_flow_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPQ = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_valid = 1'b0;
  logic [15:0] ctl_ethtype = '0, ctl_opcode = '0, ctl_quanta = '0;
  logic cfg_ignore = 1'b0, cfg_forward = 1'b0, cfg_cmd_en = 1'b0;
  logic bit_tick = 1'b1, tx_busy = 1'b0, txq_we = 1'b0;
  logic [15:0] txq_wdata = '0;
  logic tx_hold, pause_pulse, fwd, drop;
  logic [15:0] txq;

  int checks = 0, fails = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_flow_ctl u_pause_flow_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_ethtype(ctl_ethtype),
    .ctl_opcode(ctl_opcode), .ctl_quanta(ctl_quanta), .cfg_ignore(cfg_ignore),
    .cfg_forward(cfg_forward), .cfg_cmd_en(cfg_cmd_en), .bit_tick(bit_tick),
    .tx_busy(tx_busy), .txq_we(txq_we), .txq_wdata(txq_wdata), .tx_hold(tx_hold),
    .pause_pulse(pause_pulse), .fwd(fwd), .drop(drop), .txq(txq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] et, input logic [15:0] op, input logic [15:0] q,
                      input logic [2:0] exp, input string tag);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_ethtype = et; ctl_opcode = op; ctl_quanta = q;
    if (et == 16'h8808) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic measure_hold(output int n);
    int w = 0;
    n = 0;
    while (!tx_hold && w < 4) begin @(negedge clk); w++; end
    while (tx_hold && n < 100000) begin n++; @(negedge clk); end
  endtask

  always @(negedge clk) begin
    if (rst_n && (pause_pulse || fwd || drop)) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected flags actual=%b expected=000", {pause_pulse, fwd, drop});
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {29'd0, pause_pulse, fwd, drop}, {29'd0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hold", tx_hold, 0);
    check("R1 flags", {pause_pulse, fwd, drop}, 0);
    check("R1 txq", txq, 16'hF000);

    @(negedge clk); txq_we = 1'b1; txq_wdata = 16'h1234;
    @(negedge clk); txq_we = 1'b0; txq_wdata = 16'hFFFF;
    check("R10 write", txq, 16'h1234);
    @(negedge clk);
    check("R10 hold", txq, 16'h1234);

    // flags: {pulse,fwd,drop}
    cfg_ignore = 1'b1;
    cfg_forward = 1'b0; send(16'h8808, 16'h0001, 16'h0, 3'b101, "R3 pause drop");
    cfg_forward = 1'b1; send(16'h8808, 16'h0001, 16'h0, 3'b110, "R2 pause fwd");
    cfg_cmd_en = 1'b0;  send(16'h8808, 16'h0002, 16'h0, 3'b001, "R4 cmd reject");
    cfg_cmd_en = 1'b1;  send(16'h8808, 16'h0003, 16'h0, 3'b010, "R4 cmd accept");
    send(16'h0800, 16'h0001, 16'h5, 3'b000, "R11");
    send(16'h88F7, 16'h0001, 16'h5, 3'b000, "R11");
    repeat (3) @(negedge clk);
    check("R6 ignored pause no hold", tx_hold, 0);
    check("R2 queue drained", exp_q.size(), 0);

    cfg_ignore = 1'b0; cfg_forward = 1'b0;
    send(16'h8808, 16'h0001, 16'd2, 3'b101, "R3 pause drop");
    measure_hold(n);
    check("R5 hold length q=2", n, 2 * TPQ);

    send(16'h8808, 16'h0001, 16'd4, 3'b101, "R3 pause drop");
    repeat (100) @(negedge clk);
    check("R5 hold active", tx_hold, 1);
    send(16'h8808, 16'h0001, 16'd1, 3'b101, "R7 reload");
    measure_hold(n);
    check("R7 reload length", n, TPQ + 1);

    send(16'h8808, 16'h0001, 16'd3, 3'b101, "R3 pause drop");
    repeat (20) @(negedge clk);
    cfg_ignore = 1'b1;
    send(16'h8808, 16'h0001, 16'd0, 3'b101, "R6 ignore zero");
    repeat (2) @(negedge clk);
    check("R6 ignored zero keeps hold", tx_hold, 1);
    cfg_ignore = 1'b0;
    send(16'h8808, 16'h0001, 16'd0, 3'b101, "R8 zero");
    check("R8 hold before clear", tx_hold, 1);
    @(negedge clk);
    check("R8 zero clears", tx_hold, 0);

    tx_busy = 1'b1;
    send(16'h8808, 16'h0001, 16'd1, 3'b101, "R9 pause");
    repeat (10) @(negedge clk);
    check("R9 deferred while busy", tx_hold, 0);
    tx_busy = 1'b0;
    @(negedge clk);
    check("R9 hold after idle", tx_hold, 1);
    tx_busy = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 hold stays once set", tx_hold, 1);
    tx_busy = 1'b0;
    send(16'h8808, 16'h0001, 16'd0, 3'b101, "R8 zero");
    @(negedge clk);

    bit_tick = 1'b0;
    send(16'h8808, 16'h0001, 16'd1, 3'b101, "R12 pause");
    repeat (2000) @(negedge clk);
    check("R12 no tick holds", tx_hold, 1);
    bit_tick = 1'b1;
    measure_hold(n);
    check("R12 resumes", n, TPQ + 1);

    repeat (3) @(negedge clk);
    check("R11 queue empty", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule